// File: doc/BRIEF.md
# Register-Reference Execute Unit

This block carries out the register-reference class of instructions for a 16-bit accumulator machine. It holds the accumulator and a one-bit extend flag. When the sequencer strobes it with the low twelve bits of an instruction word, it performs the selected operation at the next clock edge. The operations are clearing, complementing, incrementing, a rotate through the extend flag, and a skip test.

A skip test produces a one-cycle request that the program-counter logic uses to step over the next word. A halt instruction sets a sticky flag, and the block then ignores further strobes until reset. Fetch, memory access and the other instruction classes are handled elsewhere. A side port lets a test harness or the surrounding datapath load the accumulator and the extend flag directly.

Top module: `rri_exec_unit`

## Requirements
- R1: After reset, `acc_q` and `ext_q` read 0, `skip_req` is 0 and `halted` is 0.
- R2: An instruction executes at a rising edge when all of the following hold: `op_strobe` is 1, `halted` is 0, `side_load` is 0, and exactly one bit of `op_word` is set. The bit encoding is: bit 11 clear acc, 10 clear ext, 9 complement acc, 8 complement ext, 7 rotate right, 6 rotate left, 5 increment, 4 skip if acc bit 15 is 0, 3 skip if acc bit 15 is 1, 2 skip if acc is zero, 1 skip if ext is zero, 0 halt.
- R3: Bit 11 sets acc to 0 and bit 10 sets ext to 0. Bit 9 sets acc to its bitwise complement and bit 8 inverts ext. Each of these leaves the other register unchanged.
- R4: Rotate right (bit 7) moves the 17-bit value {ext, acc} one place right: the new acc[15] is the old ext and the new ext is the old acc[0].
- R5: Rotate left (bit 6) moves {ext, acc} one place left: the new acc[0] is the old ext and the new ext is the old acc[15].
- R6: Increment (bit 5) adds one to acc, wrapping from 16'hFFFF to 0, and leaves ext unchanged.
- R7: `skip_req` is 1 for exactly the one cycle after an executing edge of a skip instruction whose condition holds on the acc and ext values before that edge. At all other times it is 0. Skip instructions do not change acc or ext.
- R8: An executed halt (bit 0) sets `halted`, which stays 1 until reset. While `halted` is 1, strobes change neither acc, ext nor `skip_req`.
- R9: With `side_load` at 1, the next edge writes `load_acc` into acc and `load_ext` into ext. This happens even when a strobe is present or the block is halted, and the strobe is then not executed.
- R10: A strobe whose `op_word` has no bit set, or more than one bit set, leaves acc, ext, `skip_req` and `halted` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_strobe | input | 1 | Execute the instruction on `op_word` at this edge |
| op_word | input | 12 | One-hot operation select, low 12 bits of the instruction |
| side_load | input | 1 | Load acc and ext from the load inputs |
| load_acc | input | 16 | Value for acc on a side load |
| load_ext | input | 1 | Value for ext on a side load |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 1 | Extend flag |
| skip_req | output | 1 | One-cycle request to skip the next instruction |
| halted | output | 1 | Sticky halt flag |

## Verification
The hardest cases to reach from the ports are the ones that depend on a specific acc and ext pattern at the moment of the strobe. Examples are a rotate that carries a 1 between ext and the end bits, an increment from 16'hFFFF, and a zero test on an exactly zero accumulator. Random one-hot operations rarely land on these states. The bench therefore sets them up with the side load port and then strobes the operation, alongside the random sequences. The halted state ends every random run, so it is entered last. It is probed with strobes and loads before a second reset.

// File: rtl/rri_pkg.sv
package rri_pkg;

  localparam int OP_W = 12;

  // bit index of each operation within the select word
  typedef enum int {
    OPI_HALT   = 0,
    OPI_SKEZ   = 1,
    OPI_SKAZ   = 2,
    OPI_SKNEG  = 3,
    OPI_SKPOS  = 4,
    OPI_INCR   = 5,
    OPI_ROTL   = 6,
    OPI_ROTR   = 7,
    OPI_INVE   = 8,
    OPI_INVA   = 9,
    OPI_CLRE   = 10,
    OPI_CLRA   = 11
  } op_idx_e;

  // decoded select lines, first member is bit 11
  typedef struct packed {
    logic clr_a;
    logic clr_e;
    logic inv_a;
    logic inv_e;
    logic rot_r;
    logic rot_l;
    logic incr;
    logic sk_pos;
    logic sk_neg;
    logic sk_az;
    logic sk_ez;
    logic halt;
  } op_sel_t;

  function automatic int unsigned count_ones(input logic [OP_W-1:0] w);
    int unsigned n;
    n = 0;
    for (int i = 0; i < OP_W; i++) n += int'(w[i]);
    return n;
  endfunction

endpackage

// File: rtl/rri_decode.sv
module rri_decode
  import rri_pkg::*;
(
  input  logic            op_strobe,
  input  logic [OP_W-1:0] op_word,
  input  logic            halted,
  input  logic            side_load,
  output logic            word_ok,
  output logic            fire,
  output op_sel_t         sel
);
  op_sel_t raw;

  assign raw     = op_sel_t'(op_word);
  assign word_ok = (count_ones(op_word) == 1);
  assign fire    = op_strobe && !halted && !side_load && word_ok;
  assign sel     = fire ? raw : '0;
endmodule

// File: rtl/rri_datapath.sv
module rri_datapath #(
  parameter int AC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            side_load,
  input  logic [AC_W-1:0] load_acc,
  input  logic            load_ext,
  input  logic            clr_a,
  input  logic            clr_e,
  input  logic            inv_a,
  input  logic            inv_e,
  input  logic            rot_r,
  input  logic            rot_l,
  input  logic            incr,
  output logic [AC_W-1:0] acc,
  output logic            ext
);
  localparam int MSB = AC_W - 1;

  function automatic logic [AC_W:0] rotate_right(input logic [AC_W-1:0] a, input logic e);
    return {a[0], e, a[MSB:1]};   // {new ext, new acc}
  endfunction

  function automatic logic [AC_W:0] rotate_left(input logic [AC_W-1:0] a, input logic e);
    return {a[MSB], a[MSB-1:0], e};
  endfunction

  function automatic logic [AC_W-1:0] bump(input logic [AC_W-1:0] a);
    return a + {{(AC_W-1){1'b0}}, 1'b1};
  endfunction

  logic [AC_W-1:0] acc_d;
  logic            ext_d;
  logic [AC_W:0]   rr, rl;

  assign rr = rotate_right(acc, ext);
  assign rl = rotate_left(acc, ext);

  always_comb begin
    acc_d = acc;
    ext_d = ext;
    if (side_load) begin
      acc_d = load_acc;
      ext_d = load_ext;
    end else if (clr_a) acc_d = '0;
    else if (clr_e) ext_d = 1'b0;
    else if (inv_a) acc_d = ~acc;
    else if (inv_e) ext_d = ~ext;
    else if (rot_r) {ext_d, acc_d} = rr;
    else if (rot_l) {ext_d, acc_d} = rl;
    else if (incr)  acc_d = bump(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ext <= 1'b0;
    end else begin
      acc <= acc_d;
      ext <= ext_d;
    end
  end
endmodule

// File: rtl/rri_skip_eval.sv
module rri_skip_eval #(
  parameter int AC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AC_W-1:0] acc,
  input  logic            ext,
  input  logic            sk_pos,
  input  logic            sk_neg,
  input  logic            sk_az,
  input  logic            sk_ez,
  output logic            skip_hit,
  output logic            skip_q
);
  localparam int NCOND = 4;

  logic [NCOND-1:0] want, cond;

  assign want = {sk_pos, sk_neg, sk_az, sk_ez};
  assign cond = {!acc[AC_W-1], acc[AC_W-1], (acc == '0), !ext};

  assign skip_hit = |(want & cond);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= 1'b0;
    else        skip_q <= skip_hit;
  end
endmodule

// File: rtl/rri_exec_unit.sv
module rri_exec_unit
  import rri_pkg::*;
#(
  parameter int AC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_strobe,
  input  logic [11:0]     op_word,
  input  logic            side_load,
  input  logic [AC_W-1:0] load_acc,
  input  logic            load_ext,
  output logic [AC_W-1:0] acc_q,
  output logic            ext_q,
  output logic            skip_req,
  output logic            halted
);
  // named internal events, observed by the checker
  logic    word_ok;
  logic    fire;
  logic    skip_hit;
  op_sel_t sel;

  rri_decode u_dec (
    .op_strobe (op_strobe),
    .op_word   (op_word),
    .halted    (halted),
    .side_load (side_load),
    .word_ok   (word_ok),
    .fire      (fire),
    .sel       (sel)
  );

  rri_datapath #(.AC_W(AC_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .side_load (side_load),
    .load_acc  (load_acc),
    .load_ext  (load_ext),
    .clr_a     (sel.clr_a),
    .clr_e     (sel.clr_e),
    .inv_a     (sel.inv_a),
    .inv_e     (sel.inv_e),
    .rot_r     (sel.rot_r),
    .rot_l     (sel.rot_l),
    .incr      (sel.incr),
    .acc       (acc_q),
    .ext       (ext_q)
  );

  rri_skip_eval #(.AC_W(AC_W)) u_skip (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc_q),
    .ext      (ext_q),
    .sk_pos   (sel.sk_pos),
    .sk_neg   (sel.sk_neg),
    .sk_az    (sel.sk_az),
    .sk_ez    (sel.sk_ez),
    .skip_hit (skip_hit),
    .skip_q   (skip_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halted <= 1'b0;
    else if (sel.halt) halted <= 1'b1;
  end
endmodule

// File: rtl/rri_exec_checker.sv
module rri_exec_checker #(
  parameter int AC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_strobe,
  input logic [11:0]     op_word,
  input logic            side_load,
  input logic [AC_W-1:0] load_acc,
  input logic            load_ext,
  input logic [AC_W-1:0] acc_q,
  input logic            ext_q,
  input logic            skip_req,
  input logic            halted,
  input logic            word_ok,
  input logic            fire
);
  assert_skip_needs_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> $past(op_strobe && !halted && !side_load));

  assert_skip_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |=> !skip_req || $past(fire));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !side_load) |=> ($stable(acc_q) && $stable(ext_q) && !skip_req));

  assert_side_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    side_load |=> (acc_q == $past(load_acc) && ext_q == $past(load_ext)));

  assert_bad_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && !side_load && !word_ok) |=>
      ($stable(acc_q) && $stable(ext_q) && !skip_req && $stable(halted)));

  assert_clear_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_word[11]) |=> (acc_q == '0));

  assert_incr_keeps_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_word[5]) |=> $stable(ext_q));
endmodule

bind rri_exec_unit rri_exec_checker #(.AC_W(AC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_strobe (op_strobe),
  .op_word   (op_word),
  .side_load (side_load),
  .load_acc  (load_acc),
  .load_ext  (load_ext),
  .acc_q     (acc_q),
  .ext_q     (ext_q),
  .skip_req  (skip_req),
  .halted    (halted),
  .word_ok   (word_ok),
  .fire      (fire)
);

// File: tb/sim_rri_exec_unit.sv
module sim_rri_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_strobe = 1'b0;
  logic [11:0] op_word = '0;
  logic        side_load = 1'b0;
  logic [15:0] load_acc = '0;
  logic        load_ext = 1'b0;
  logic [15:0] acc_q;
  logic        ext_q, skip_req, halted;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_acc;
  logic        m_ext, m_halt;

  always #10 clk = ~clk;   // 50 MHz

  rri_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_strobe(op_strobe), .op_word(op_word),
    .side_load(side_load), .load_acc(load_acc), .load_ext(load_ext),
    .acc_q(acc_q), .ext_q(ext_q), .skip_req(skip_req), .halted(halted)
  );

  function automatic logic [16:0] ref_rot(input logic [15:0] a, input logic e, input bit right);
    logic [16:0] v;
    v = {e, a};
    if (right) v = {v[0], v[16:1]};
    else       v = {v[15:0], v[16]};
    return v;   // {new ext, new acc}
  endfunction

  function automatic bit ref_skip(input int idx, input logic [15:0] a, input logic e);
    case (idx)
      4: return a < 16'h8000;
      3: return a >= 16'h8000;
      2: return a == 16'd0;
      1: return e == 1'b0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic step(input string tag, input logic v, input logic [11:0] w,
                      input logic ld, input logic [15:0] la, input logic le);
    bit fire, sk;
    int idx;
    logic [16:0] r;
    op_strobe = v; op_word = w; side_load = ld; load_acc = la; load_ext = le;
    fire = v && !m_halt && !ld && ($countones(w) == 1);
    sk = 0;
    idx = -1;
    for (int i = 0; i < 12; i++) if (w[i]) idx = i;
    if (ld) begin
      m_acc = la; m_ext = le;
    end else if (fire) begin
      case (idx)
        11: m_acc = 16'h0000;
        10: m_ext = 1'b0;
        9:  m_acc = m_acc ^ 16'hFFFF;
        8:  m_ext = !m_ext;
        7:  begin r = ref_rot(m_acc, m_ext, 1); m_ext = r[16]; m_acc = r[15:0]; end
        6:  begin r = ref_rot(m_acc, m_ext, 0); m_ext = r[16]; m_acc = r[15:0]; end
        5:  m_acc = 16'((32'(m_acc) + 1) % 65536);
        0:  m_halt = 1'b1;
        default: sk = ref_skip(idx, m_acc, m_ext);
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, 32'(acc_q), 32'(m_acc), "acc");
    check(tag, 32'(ext_q), 32'(m_ext), "ext");
    check(tag, 32'(skip_req), 32'(sk), "skip");
    check(tag, 32'(halted), 32'(m_halt), "halted");
  endtask

  task automatic op(input string tag, input int idx);
    step(tag, 1'b1, 12'(1 << idx), 1'b0, 16'h0, 1'b0);
  endtask

  task automatic preset(input logic [15:0] a, input logic e);
    step("R9", 1'b0, 12'h0, 1'b1, a, e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op_strobe = 0; side_load = 0;
    m_acc = '0; m_ext = 0; m_halt = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(acc_q), 0, "acc");
    check("R1", 32'(ext_q), 0, "ext");
    check("R1", 32'(skip_req), 0, "skip");
    check("R1", 32'(halted), 0, "halted");
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] w;
    void'($urandom(32'h5A17));
    do_reset();

    // R3 clears and complements
    preset(16'h1234, 1'b1);
    op("R3", 9); op("R3", 8); op("R3", 11); op("R3", 10);
    // R4 rotate right carrying ones
    preset(16'h0001, 1'b1); op("R4", 7); op("R4", 7);
    preset(16'hA5A4, 1'b0); op("R4", 7);
    // R5 rotate left
    preset(16'h8000, 1'b0); op("R5", 6); op("R5", 6);
    preset(16'h7FFF, 1'b1); op("R5", 6);
    // R6 increment wrap, ext kept
    preset(16'hFFFF, 1'b1); op("R6", 5); op("R6", 5);
    // R7 skip tests, true and false
    preset(16'h0000, 1'b0);
    op("R7", 4); op("R7", 3); op("R7", 2); op("R7", 1);
    step("R7", 1'b0, 12'h0, 1'b0, 16'h0, 1'b0);
    preset(16'h8000, 1'b1);
    op("R7", 4); op("R7", 3); op("R7", 2); op("R7", 1);
    preset(16'h7FFF, 1'b0); op("R7", 4); op("R7", 2);
    // R10 malformed words
    step("R10", 1'b1, 12'h000, 1'b0, 16'h0, 1'b0);
    step("R10", 1'b1, 12'h810, 1'b0, 16'h0, 1'b0);
    step("R10", 1'b1, 12'hFFF, 1'b0, 16'h0, 1'b0);
    // R9 load wins over a strobe
    step("R9", 1'b1, 12'h800, 1'b1, 16'hBEEF, 1'b1);
    // R2 strobe low with a word present
    step("R2", 1'b0, 12'h200, 1'b0, 16'h0, 1'b0);

    // R2 random mix of operations, loads and idle cycles
    for (int k = 0; k < 1500; k++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) preset(16'($urandom), 1'($urandom));
      else if (r == 1) begin
        w = 12'($urandom);
        if ($countones(w) == 1) w = w ^ (w == 12'h001 ? 12'h002 : 12'h001);
        step("R10", 1'b1, w, 1'b0, 16'h0, 1'b0);
      end else if (r == 2) step("R2", 1'b0, 12'($urandom), 1'b0, 16'h0, 1'b0);
      else op("R2", 1 + int'($urandom % 11));
    end

    // R8 halt and frozen state
    preset(16'h00F0, 1'b1);
    op("R8", 0);
    op("R8", 11); op("R8", 2); op("R8", 5); op("R8", 0);
    step("R9", 1'b0, 12'h0, 1'b1, 16'h1357, 1'b0);
    op("R8", 9);
    do_reset();
    op("R3", 9);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule